// File: doc/BRIEF.md
# Gold Spreading Code Generator with Phase Setter

This block produces a 1023-chip Gold spreading sequence. It combines two 10-stage linear feedback shift registers, a base register (A) and a selector register (B). The sequence is chosen by a pair of stage taps on register B. Both registers step once per chip. The chip rate is the incoming code clock divided by ten, gated by a chip enable. Single-chip advance and retard commands slip the phase by one chip in either direction.

A shared setter counter tracks register shifts from 0 to 511, which is half a code period, and then wraps. Software arms a set request and names a target: the period start or the period midpoint. At the next wrap of the setter, both registers are loaded with the matching state instead of shifting, and the request clears. The wait from arming to the load is therefore at most half a code period. The software code accumulator can then count from a known phase. An epoch strobe marks the chips during which register A holds its all-ones start state.

Top module: `gold_code_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both registers are set to all ones, the setter count is 0, the divider phase is 0, and any pending command or armed request is dropped.
- R2: With `chip_en` high, the registers shift once every 10 clocks, on the 10th enabled edge of each divider period. While `chip_en` is low, no shift happens and the divider phase is held.
- R3: Stage k is bit k-1. On a shift each stage moves one stage higher and stage 1 takes the feedback. Register A feeds back stage 3 xor stage 10. Register B feeds back the xor of stages 2, 3, 6, 8, 9 and 10. `chip` is A stage 10 xor B at stage `tap_a` xor B at stage `tap_b`.
- R4: `tap_a` and `tap_b` select B stages 1 to 10 combinationally and do not change the phase. Any other tap value contributes 0.
- R5: `epoch` is high exactly while register A holds all ones.
- R6: `set_count` rises by one on every shift and wraps from 511 to 0.
- R7: A `set_req` pulse with `set_mid` low arms a load of the all-ones start state into both registers. The load replaces the shift that wraps the setter, `set_count` becomes 0, and the request clears, so the next wrap shifts normally.
- R8: With `set_mid` high, the load puts both registers in the state they reach 512 shifts after all ones.
- R9: An `advance` pulse given at the start of a divider period adds one extra shift within that period, on its 5th enabled edge.
- R10: A `retard` pulse given at the start of a divider period suppresses the shift at the end of that period.
- R11: An armed request does not disturb the sequence or the setter count before the setter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code clock, ten times the chip rate |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Enables the chip-rate divider |
| tap_a | input | 4 | First selector-register tap, stage 1..10 |
| tap_b | input | 4 | Second selector-register tap, stage 1..10 |
| set_req | input | 1 | One-cycle pulse arming a phase load |
| set_mid | input | 1 | Load target sampled with `set_req`: 0 start, 1 midpoint |
| advance | input | 1 | One-cycle pulse adding one chip shift |
| retard | input | 1 | One-cycle pulse removing one chip shift |
| chip | output | 1 | Current code chip |
| epoch | output | 1 | High while the base register is all ones |
| set_count | output | 9 | Setter count, 0 to 511 |

## Verification
Each shift lands on the 10th enabled clock edge after a period start. The bench waits exactly ten rising edges per chip and samples `chip`, `epoch` and `set_count` on the following falling edge. Commands are pulsed during the first edge of a period. An advance therefore shows up as two shifts at the end of that period, a retard as none, and a load in the period whose shift wraps the setter. Tap changes are combinational, so they are checked on the same falling edge one time unit after the change. During a hold with the enable low, outputs are checked after many idle edges.

// File: rtl/gold_pkg.sv
package gold_pkg;
    localparam int STAGES   = 10;
    localparam int DIV      = 10;
    localparam int ADV_SLOT = 4;
    localparam int HALF     = 512;
    localparam int CNT_W    = $clog2(HALF);
    localparam int DIV_W    = $clog2(DIV);
    localparam int TAP_W    = $clog2(STAGES + 1);
    localparam int NTAPS    = 2;

    typedef logic [STAGES-1:0] stage_t;

    typedef struct packed {
        stage_t a;
        stage_t b;
    } pair_t;

    localparam stage_t ONES = '1;
    localparam stage_t FB_A = stage_t'(10'b10_0000_0100);
    localparam stage_t FB_B = stage_t'(10'b11_1010_0110);

    function automatic stage_t shift_reg(stage_t r, stage_t mask);
        return {r[STAGES-2:0], ^(r & mask)};
    endfunction

    function automatic pair_t shift_pair(pair_t p);
        pair_t n;
        n.a = shift_reg(p.a, FB_A);
        n.b = shift_reg(p.b, FB_B);
        return n;
    endfunction

    function automatic pair_t pair_after(int n);
        pair_t p;
        p.a = ONES;
        p.b = ONES;
        for (int i = 0; i < n; i++) p = shift_pair(p);
        return p;
    endfunction

    localparam pair_t START = pair_after(0);
    localparam pair_t MID   = pair_after(HALF);
endpackage

// File: rtl/gold_divider.sv
module gold_divider import gold_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic adv,
    input  logic ret,
    output logic step
);
    logic [DIV_W-1:0] cnt;
    logic adv_p, ret_p, tick, slot;

    assign tick = en && (cnt == DIV_W'(DIV - 1));
    assign slot = en && (cnt == DIV_W'(ADV_SLOT));
    assign step = (tick && !ret_p) || (slot && adv_p);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            adv_p <= 1'b0;
            ret_p <= 1'b0;
        end else begin
            if (en) cnt <= tick ? '0 : cnt + 1'b1;
            adv_p <= adv || (adv_p && !slot);
            ret_p <= ret || (ret_p && !tick);
        end
    end

    // R2: the divider phase holds while the enable is low
    a_r2_freeze: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));
    // R9: a pending advance survives until the mid-period slot
    a_r9_adv_wait: assert property (@(posedge clk) disable iff (rst)
        (adv_p && !slot) |=> adv_p);
    // R10: a pending retard survives until the period end
    a_r10_ret_wait: assert property (@(posedge clk) disable iff (rst)
        (ret_p && !tick) |=> ret_p);
endmodule

// File: rtl/gold_setter.sv
module gold_setter import gold_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             set_req,
    input  logic             set_mid,
    output logic             load,
    output logic             load_mid,
    output logic [CNT_W-1:0] count
);
    logic armed, tgt_mid, wrap;

    assign wrap     = step && (count == CNT_W'(HALF - 1));
    assign load     = wrap && armed;
    assign load_mid = tgt_mid;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            armed   <= 1'b0;
            tgt_mid <= 1'b0;
        end else begin
            if (step) count <= wrap ? '0 : count + 1'b1;
            if (set_req) begin
                armed   <= 1'b1;
                tgt_mid <= set_mid;
            end else if (load) begin
                armed   <= 1'b0;
            end
        end
    end

    // R6: wrap from the last count to zero
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count == '0));
    // R6: every other shift adds one
    a_r6_count_up: assert property (@(posedge clk) disable iff (rst)
        (step && !wrap) |=> (count == $past(count) + 1'b1));
    // R7: a completed load disarms the request
    a_r7_disarm: assert property (@(posedge clk) disable iff (rst)
        (load && !set_req) |=> !armed);
endmodule

// File: rtl/gold_lfsr_pair.sv
module gold_lfsr_pair import gold_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             load,
    input  logic             load_mid,
    input  logic [TAP_W-1:0] tap_a,
    input  logic [TAP_W-1:0] tap_b,
    output logic             chip,
    output logic             epoch
);
    pair_t st;
    logic [TAP_W-1:0] tap_sel [NTAPS];
    logic [NTAPS-1:0] tap_bit;

    assign tap_sel[0] = tap_a;
    assign tap_sel[1] = tap_b;

    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        logic sel_bit;
        always_comb begin
            sel_bit = 1'b0;
            for (int i = 0; i < STAGES; i++)
                if (tap_sel[g] == TAP_W'(i + 1)) sel_bit = st.b[i];
        end
        assign tap_bit[g] = sel_bit;
    end

    assign chip  = st.a[STAGES-1] ^ (^tap_bit);
    assign epoch = (st.a == ONES);

    always_ff @(posedge clk) begin
        if (rst)       st <= START;
        else if (load) st <= load_mid ? MID : START;
        else if (step) st <= shift_pair(st);
    end

    // R7: a start-target load leaves both registers all ones
    a_r7_start_load: assert property (@(posedge clk) disable iff (rst)
        (load && !load_mid) |=> (st.a == ONES && st.b == ONES));
    // R8: a midpoint load leaves the stored midpoint state
    a_r8_mid_load: assert property (@(posedge clk) disable iff (rst)
        (load && load_mid) |=> (st == MID));
    // R2: no shift, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(st));
endmodule

// File: rtl/gold_code_gen.sv
module gold_code_gen import gold_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             chip_en,
    input  logic [TAP_W-1:0] tap_a,
    input  logic [TAP_W-1:0] tap_b,
    input  logic             set_req,
    input  logic             set_mid,
    input  logic             advance,
    input  logic             retard,
    output logic             chip,
    output logic             epoch,
    output logic [CNT_W-1:0] set_count
);
    logic step, load, load_mid;

    gold_divider u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (chip_en),
        .adv  (advance),
        .ret  (retard),
        .step (step)
    );

    gold_setter u_set (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .set_req  (set_req),
        .set_mid  (set_mid),
        .load     (load),
        .load_mid (load_mid),
        .count    (set_count)
    );

    gold_lfsr_pair u_regs (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .load     (load),
        .load_mid (load_mid),
        .tap_a    (tap_a),
        .tap_b    (tap_b),
        .chip     (chip),
        .epoch    (epoch)
    );
endmodule

// File: tb/test_gold_code_gen.sv
module test_gold_code_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CHIP_CLKS  = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chip_en = 1'b0;
    logic [3:0] tap_a = 4'd2;
    logic [3:0] tap_b = 4'd6;
    logic       set_req = 1'b0;
    logic       set_mid = 1'b0;
    logic       advance = 1'b0;
    logic       retard = 1'b0;
    logic       chip, epoch;
    logic [8:0] set_count;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [9:0] ma, mb;
    int         ms;
    bit         m_arm, m_mid;
    logic [9:0] mid_a, mid_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    gold_code_gen i_gold_code_gen (
        .clk(clk), .rst(rst), .chip_en(chip_en), .tap_a(tap_a), .tap_b(tap_b),
        .set_req(set_req), .set_mid(set_mid), .advance(advance), .retard(retard),
        .chip(chip), .epoch(epoch), .set_count(set_count)
    );

    function automatic logic [9:0] nxt_a(logic [9:0] r);
        return {r[8:0], r[2] ^ r[9]};
    endfunction

    function automatic logic [9:0] nxt_b(logic [9:0] r);
        return {r[8:0], r[1] ^ r[2] ^ r[5] ^ r[7] ^ r[8] ^ r[9]};
    endfunction

    function automatic logic stage_of(logic [9:0] r, logic [3:0] t);
        if (t >= 4'd1 && t <= 4'd10) return r[t - 1];
        return 1'b0;
    endfunction

    function automatic logic exp_chip();
        return ma[9] ^ stage_of(mb, tap_a) ^ stage_of(mb, tap_b);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " R3 chip"}, chip, exp_chip());
        chk({tag, " R5 epoch"}, epoch, (ma == 10'h3FF));
        chk({tag, " R6 count"}, set_count, ms);
    endtask

    task automatic model_shift();
        if (m_arm && ms == 511) begin
            ma = m_mid ? mid_a : 10'h3FF;
            mb = m_mid ? mid_b : 10'h3FF;
            ms = 0;
            m_arm = 1'b0;
        end else begin
            ma = nxt_a(ma);
            mb = nxt_b(mb);
            ms = (ms + 1) % 512;
        end
    endtask

    // one divider period; optional command pulse in its first edge
    task automatic period(bit adv_v, bit ret_v, bit req_v, bit mid_v);
        advance = adv_v; retard = ret_v; set_req = req_v; set_mid = mid_v;
        @(posedge clk);
        @(negedge clk);
        advance = 1'b0; retard = 1'b0; set_req = 1'b0;
        repeat (CHIP_CLKS - 1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_chips(int n, string tag);
        for (int i = 0; i < n; i++) begin
            period(1'b0, 1'b0, 1'b0, 1'b0);
            model_shift();
            check_all(tag);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; chip_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ma = 10'h3FF; mb = 10'h3FF; ms = 0; m_arm = 1'b0; m_mid = 1'b0;
        check_all("R1 reset");
        rst = 1'b0; chip_en = 1'b1;
    endtask

    task automatic t_basic();
        // R2: exactly one shift after ten edges, none before
        repeat (CHIP_CLKS - 1) @(posedge clk);
        @(negedge clk);
        chk("R2 no early shift", set_count, 0);
        @(posedge clk);
        @(negedge clk);
        model_shift();
        check_all("R2 first shift");
        run_chips(30, "R3 run");
    endtask

    task automatic t_taps();
        tap_a = 4'd3; tap_b = 4'd7;
        #1;
        check_all("R4 tap change");
        run_chips(20, "R4 new pair");
        tap_b = 4'd0;
        #1;
        check_all("R4 out-of-range tap");
        run_chips(5, "R4 single tap");
        tap_a = 4'd10; tap_b = 4'd1;
        #1;
        check_all("R4 end stages");
        run_chips(5, "R4 end pair");
        tap_a = 4'd2; tap_b = 4'd6;
    endtask

    task automatic t_freeze();
        chip_en = 1'b0;
        repeat (25) @(negedge clk);
        check_all("R2 freeze");
        chip_en = 1'b1;
        run_chips(2, "R2 resume");
    endtask

    task automatic t_slip();
        period(1'b1, 1'b0, 1'b0, 1'b0);
        model_shift(); model_shift();
        check_all("R9 advance");
        run_chips(2, "R9 after");
        period(1'b0, 1'b1, 1'b0, 1'b0);
        check_all("R10 retard");
        run_chips(2, "R10 after");
    endtask

    task automatic t_set(bit mid_v, string tag);
        period(1'b0, 1'b0, 1'b1, mid_v);
        m_arm = 1'b1; m_mid = mid_v;
        model_shift();
        check_all({tag, " R11 armed"});
        while (m_arm) begin
            period(1'b0, 1'b0, 1'b0, 1'b0);
            model_shift();
            check_all({tag, " R11 pending"});
        end
        chk({tag, " load count"}, set_count, 0);
        run_chips(8, tag);
    endtask

    task automatic t_epoch();
        int seen = 0;
        for (int i = 0; i < 1023; i++) begin
            period(1'b0, 1'b0, 1'b0, 1'b0);
            model_shift();
            check_all("R5 full period");
            if (epoch) seen++;
        end
        chk("R5 one epoch per period", seen, 1);
        // R7: request cleared, this wrap shifts normally
        run_chips(520 - 1031 % 512, "R7 cleared");
    endtask

    initial begin
        mid_a = 10'h3FF; mid_b = 10'h3FF;
        for (int i = 0; i < 512; i++) begin
            mid_a = nxt_a(mid_a);
            mid_b = nxt_b(mid_b);
        end
        t_reset();
        t_basic();
        t_taps();
        t_freeze();
        t_slip();
        t_set(1'b0, "R7 start load");
        t_epoch();
        t_set(1'b1, "R8 mid load");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule